// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block supplies the two divided clocks that a fractional-N frequency synthesizer compares. A reference path divides a slow reference clock by a power of two chosen from 1, 2, 4 and 8. A feedback path takes the fast oscillator clock and halves it in a fixed prescaler. It then divides the result by a programmable modulus. In integer mode the modulus stays fixed. In fractional mode a first-order delta-sigma accumulator picks either M or M+1 for each output period. Over time the average modulus becomes M + K/2^32, so the synthesized frequency equals 2 × (M + K/2^32) × reference / N.

Settings are sampled in two situations: continuously while the block is idle, and otherwise only at the last input cycle of a feedback period, so no period is ever cut short. An illegal modulus is clamped to the nearest legal bound for the active mode. A zero fraction in fractional mode is treated as one. Either case sets a sticky configuration error. A separate flag tells the lock detector whether its indication can be trusted. The flag drops when the fraction lies close to an integer boundary.

Top module: `fracn_fb_divider`

## Requirements
- R1: After reset both divided outputs are low, `cfg_err_o` is 0 and `lock_ok_o` is 1, and a reset clears a set `cfg_err_o`.
- R2: `n_code_i` values 0, 1, 2, 3 divide the reference clock by 1, 2, 4, 8. With the default half duty, code 0 passes the reference clock through while enabled. Other codes drive the output high for the first half of each divided period. The code is sampled while idle or on the last reference cycle of a period.
- R3: In integer mode (`frac_i`=0) with M in 8..127, every feedback period lasts exactly 2·M fast-clock cycles. With the half duty, the output is high for the first M cycles of each period.
- R4: In fractional mode (`frac_i`=1), the first P feedback periods after enabling last 2·(M·P + floor(K·P/2^32)) fast-clock cycles in total.
- R5: In fractional mode every single feedback period lasts either 2·M or 2·(M+1) fast-clock cycles.
- R6: A modulus below the mode's lower bound (8 integer, 11 fractional) or above its upper bound (127 integer, 123 fractional) is used as that bound. K=0 in fractional mode is used as K=1. Either case sets `cfg_err_o`, which stays 1 until reset.
- R7: A change of M, K or mode while running takes effect from the next feedback period. The period in progress completes with its old modulus.
- R8: `lock_ok_o` is 0 in fractional mode when K ≤ 429496729 or K ≥ 3865470567, and 1 for other K and always in integer mode. It follows the settings sampled under R7.
- R9: Deasserting `en_i` drives the feedback output low after one fast-clock edge and the reference output low after one reference-clock edge. Re-enabling starts a fresh feedback period with the accumulator restarted.
- R10: With the pulse duty variant, each output is high for only the first input cycle of every divided period. For code 0 this holds the reference output high while enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast oscillator clock feeding the feedback path |
| ref_clk_i | input | 1 | Reference clock feeding the pre-divider |
| rst_ni | input | 1 | Asynchronous active-low reset for both clock domains |
| en_i | input | 1 | Enable; low holds both outputs low and restarts the divider |
| frac_i | input | 1 | Mode select: 0 integer, 1 fractional |
| m_i | input | M_W (8) | Integer part of the feedback modulus |
| k_i | input | K_W (32) | Fraction numerator K over 2^K_W |
| n_code_i | input | NC_W (2) | Reference divide code, ratio 2^code |
| ref_div_o | output | 1 | Divided reference clock |
| fb_div_o | output | 1 | Divided feedback clock |
| lock_ok_o | output | 1 | Lock indication may be trusted |
| cfg_err_o | output | 1 | Sticky flag for clamped or substituted settings |

## Verification
A wrong accumulator value or a dropped carry does not change the length of any single period beyond 2·M or 2·(M+1). It only shifts the total cycle count of a long window by one or more double-cycles. The bench therefore sums hundreds of periods and compares the total to the exact closed form, so a single missed carry shows up within one measurement window. A modulus loaded at the wrong moment shows up at once as a period of the wrong length next to a settings change. A clamp or sticky flag fault shows up at the error and lock pins a couple of fast cycles after the settings are written while idle.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

   typedef enum logic {
      DUTY_HALF  = 1'b0,
      DUTY_PULSE = 1'b1
   } duty_e;

   // Floor of (tenths/10) * 2^fw, used for the lock-valid thresholds.
   function automatic logic [63:0] frac_bound(input int unsigned fw, input int unsigned tenths);
      return ((64'd1 << fw) * 64'(tenths)) / 64'd10;
   endfunction

endpackage

// File: rtl/fracn_ref_prediv.sv
module fracn_ref_prediv
   import fracn_pkg::*;
#(
   parameter int    NC_W = 2,
   parameter duty_e DUTY = DUTY_HALF
) (
   input  logic            ref_clk_i,
   input  logic            rst_ni,
   input  logic            en_i,
   input  logic [NC_W-1:0] n_code_i,
   output logic            ref_o
);

   localparam int RC_W = (1 << NC_W) - 1;

   logic            en_q;
   logic [NC_W-1:0] n_q;
   logic [RC_W-1:0] rc_q;
   logic [RC_W-1:0] last_c;
   logic            wrap_c;

   assign last_c = ~(~RC_W'(0) << n_q);
   assign wrap_c = (rc_q == last_c);

   always_ff @(posedge ref_clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q <= 1'b0;
         n_q  <= '0;
         rc_q <= '0;
      end else begin
         en_q <= en_i;
         if (!en_q) begin
            rc_q <= '0;
            n_q  <= n_code_i;
         end else if (wrap_c) begin
            rc_q <= '0;
            n_q  <= n_code_i;
         end else begin
            rc_q <= rc_q + 1'b1;
         end
      end
   end

   generate
      if (DUTY == DUTY_PULSE) begin : g_pulse
         assign ref_o = en_q && (rc_q == '0);
      end else begin : g_half
         assign ref_o = en_q && ((n_q == '0) ? ref_clk_i : (rc_q <= (last_c >> 1)));
      end
   endgenerate

   // R2
   rc_bound_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
      rc_q <= last_c);

   // R2
   n_hold_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
      (en_q && !wrap_c) |=> $stable(n_q));

   // R9
   ref_idle_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
      !en_q |=> (rc_q == '0));

endmodule

// File: rtl/fracn_dsm.sv
module fracn_dsm
   import fracn_pkg::*;
#(
   parameter int M_W      = 8,
   parameter int K_W      = 32,
   parameter int INT_MIN  = 8,
   parameter int INT_MAX  = 127,
   parameter int FRAC_MIN = 11,
   parameter int FRAC_MAX = 123
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           idle_i,
   input  logic           load_i,
   input  logic           frac_i,
   input  logic [M_W-1:0] m_i,
   input  logic [K_W-1:0] k_i,
   output logic [M_W-1:0] mod_o,
   output logic           lock_ok_o,
   output logic           cfg_err_o
);

   localparam logic [K_W-1:0] LOCK_LO = K_W'(frac_bound(K_W, 1));
   localparam logic [K_W-1:0] LOCK_HI = K_W'(frac_bound(K_W, 9));
   localparam int MOD_LO = (INT_MIN < FRAC_MIN) ? INT_MIN : FRAC_MIN;
   localparam int MOD_HI = (INT_MAX > FRAC_MAX + 1) ? INT_MAX : FRAC_MAX + 1;

   logic [K_W-1:0] acc_q;
   logic [M_W-1:0] mod_q;
   logic           lock_q;
   logic           err_q;

   logic [M_W-1:0] lo_c, hi_c, m_c, next_mod_c;
   logic [K_W-1:0] k_c;
   logic [K_W:0]   sum_c;
   logic           bad_c, lock_c, cap_c;

   always_comb begin
      lo_c  = frac_i ? M_W'(FRAC_MIN) : M_W'(INT_MIN);
      hi_c  = frac_i ? M_W'(FRAC_MAX) : M_W'(INT_MAX);
      if (m_i < lo_c)      m_c = lo_c;
      else if (m_i > hi_c) m_c = hi_c;
      else                 m_c = m_i;
      if (!frac_i)         k_c = '0;
      else if (k_i == '0)  k_c = K_W'(1);
      else                 k_c = k_i;
      bad_c      = (m_c != m_i) || (frac_i && (k_i == '0));
      sum_c      = {1'b0, acc_q} + {1'b0, k_c};
      next_mod_c = m_c + M_W'(sum_c[K_W]);
      lock_c     = !frac_i || ((k_c > LOCK_LO) && (k_c <= LOCK_HI));
      cap_c      = idle_i || load_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q  <= '0;
         mod_q  <= M_W'(INT_MIN);
         lock_q <= 1'b1;
         err_q  <= 1'b0;
      end else if (idle_i) begin
         // Prime: the first period uses M, the accumulator already holds 0 + K.
         acc_q  <= k_c;
         mod_q  <= m_c;
         lock_q <= lock_c;
         err_q  <= err_q || bad_c;
      end else if (load_i) begin
         acc_q  <= sum_c[K_W-1:0];
         mod_q  <= next_mod_c;
         lock_q <= lock_c;
         err_q  <= err_q || bad_c;
      end
   end

   assign mod_o     = mod_q;
   assign lock_ok_o = lock_q;
   assign cfg_err_o = err_q;

   // R5
   mod_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mod_q >= M_W'(MOD_LO)) && (mod_q <= M_W'(MOD_HI)));

   // R5
   mod_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && !idle_i) |=> ((mod_q == $past(m_c)) || (mod_q == $past(m_c) + 1'b1)));

   // R7
   mod_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cap_c |=> $stable(mod_q));

   // R6
   err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_q |=> err_q);

   // R6
   err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cap_c && bad_c) |=> err_q);

   // R8
   lock_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (idle_i && !frac_i) |=> lock_q);

endmodule

// File: rtl/fracn_mod_counter.sv
module fracn_mod_counter
   import fracn_pkg::*;
#(
   parameter int    M_W  = 8,
   parameter duty_e DUTY = DUTY_HALF
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           run_i,
   input  logic [M_W-1:0] mod_i,
   output logic           tc_o,
   output logic           fb_o
);

   logic           ph_q;
   logic [M_W-1:0] cnt_q;

   // Terminal count: last fast cycle of the period (prescaler phase 1, last count).
   assign tc_o = run_i && ph_q && (cnt_q == mod_i - 1'b1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q  <= 1'b0;
         cnt_q <= '0;
      end else if (!run_i) begin
         ph_q  <= 1'b0;
         cnt_q <= '0;
      end else begin
         ph_q <= ~ph_q;
         if (ph_q) begin
            cnt_q <= tc_o ? '0 : cnt_q + 1'b1;
         end
      end
   end

   generate
      if (DUTY == DUTY_PULSE) begin : g_pulse
         assign fb_o = run_i && (cnt_q == '0) && !ph_q;
      end else begin : g_half
         assign fb_o = run_i && ({cnt_q, ph_q} < {1'b0, mod_i});
      end
   endgenerate

   // R3
   cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < mod_i);

   // R3
   ph_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i |=> (ph_q != $past(ph_q)) || !run_i);

   // R9
   idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> ((cnt_q == '0) && !ph_q));

endmodule

// File: rtl/fracn_fb_divider.sv
module fracn_fb_divider
   import fracn_pkg::*;
#(
   parameter int    M_W      = 8,
   parameter int    K_W      = 32,
   parameter int    NC_W     = 2,
   parameter int    INT_MIN  = 8,
   parameter int    INT_MAX  = 127,
   parameter int    FRAC_MIN = 11,
   parameter int    FRAC_MAX = 123,
   parameter duty_e DUTY     = DUTY_HALF
) (
   input  logic            clk_i,
   input  logic            ref_clk_i,
   input  logic            rst_ni,
   input  logic            en_i,
   input  logic            frac_i,
   input  logic [M_W-1:0]  m_i,
   input  logic [K_W-1:0]  k_i,
   input  logic [NC_W-1:0] n_code_i,
   output logic            ref_div_o,
   output logic            fb_div_o,
   output logic            lock_ok_o,
   output logic            cfg_err_o
);

   localparam int M_LIMIT = (1 << M_W) - 1;

   if (K_W < 2 || K_W > 60) begin : g_bad_kw
      $error("fracn_fb_divider: K_W must lie in 2..60");
   end
   if (NC_W < 1 || NC_W > 4) begin : g_bad_ncw
      $error("fracn_fb_divider: NC_W must lie in 1..4");
   end
   if (INT_MIN < 2 || INT_MIN > INT_MAX || INT_MAX > M_LIMIT) begin : g_bad_int
      $error("fracn_fb_divider: integer modulus bounds do not fit M_W");
   end
   if (FRAC_MIN < 2 || FRAC_MIN > FRAC_MAX || FRAC_MAX + 1 > M_LIMIT) begin : g_bad_frac
      $error("fracn_fb_divider: fractional modulus bounds do not fit M_W");
   end

   logic           run_q;
   logic           tc_w;
   logic [M_W-1:0] mod_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) run_q <= 1'b0;
      else         run_q <= en_i;
   end

   fracn_ref_prediv #(
      .NC_W (NC_W),
      .DUTY (DUTY)
   ) u_ref (
      .ref_clk_i (ref_clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i),
      .n_code_i  (n_code_i),
      .ref_o     (ref_div_o)
   );

   fracn_dsm #(
      .M_W      (M_W),
      .K_W      (K_W),
      .INT_MIN  (INT_MIN),
      .INT_MAX  (INT_MAX),
      .FRAC_MIN (FRAC_MIN),
      .FRAC_MAX (FRAC_MAX)
   ) u_dsm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .idle_i    (!run_q),
      .load_i    (tc_w),
      .frac_i    (frac_i),
      .m_i       (m_i),
      .k_i       (k_i),
      .mod_o     (mod_w),
      .lock_ok_o (lock_ok_o),
      .cfg_err_o (cfg_err_o)
   );

   fracn_mod_counter #(
      .M_W  (M_W),
      .DUTY (DUTY)
   ) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_q),
      .mod_i  (mod_w),
      .tc_o   (tc_w),
      .fb_o   (fb_div_o)
   );

   // R9
   fb_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !fb_div_o);

endmodule

// File: tb/tb_fracn_fb_divider.sv
module tb_fracn_fb_divider;
   import fracn_pkg::*;

   logic        clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
   logic        en = 1'b0, frac = 1'b0;
   logic [7:0]  m = 8'd8;
   logic [31:0] k = '0;
   logic [1:0]  nc = '0;
   logic        ref_o, fb_o, lock_ok, err;
   logic        ref_p, fb_p, lock_p, err_p;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;
   always #7 ref_clk = ~ref_clk;

   fracn_fb_divider dut (
      .clk_i(clk), .ref_clk_i(ref_clk), .rst_ni(rst_n), .en_i(en), .frac_i(frac),
      .m_i(m), .k_i(k), .n_code_i(nc),
      .ref_div_o(ref_o), .fb_div_o(fb_o), .lock_ok_o(lock_ok), .cfg_err_o(err));

   fracn_fb_divider #(.DUTY(DUTY_PULSE)) dut_pulse (
      .clk_i(clk), .ref_clk_i(ref_clk), .rst_ni(rst_n), .en_i(en), .frac_i(frac),
      .m_i(m), .k_i(k), .n_code_i(nc),
      .ref_div_o(ref_p), .fb_div_o(fb_p), .lock_ok_o(lock_p), .cfg_err_o(err_p));

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint frac_total(input longint mv, input logic [31:0] kv, input int p);
      logic [63:0] prod = 64'(kv) * 64'(p);
      return 2 * (mv * p + longint'(prod >> 32));
   endfunction

   task automatic restart(input logic f, input logic [7:0] mv, input logic [31:0] kv, input logic [1:0] nv);
      @(negedge clk);
      en = 1'b0; frac = f; m = mv; k = kv; nc = nv;
      repeat (5) @(negedge clk);
      en = 1'b1;
   endtask

   task automatic pulse_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Sums fast cycles over p feedback periods starting at the next rising edge.
   task automatic measure_fb(input int p, input int mlo, output longint cyc,
                             output int hi, output int hp, output int badl);
      logic pv;
      int r = 0, len = 0;
      cyc = 0; hi = 0; hp = 0; badl = 0;
      do begin
         pv = fb_o;
         @(negedge clk);
      end while (!(fb_o && !pv));
      while (r < p) begin
         cyc++; len++;
         if (fb_o) hi++;
         if (fb_p) hp++;
         pv = fb_o;
         @(negedge clk);
         if (fb_o && !pv) begin
            r++;
            if (len != 2 * mlo && len != 2 * mlo + 2) badl++;
            len = 0;
         end
      end
   endtask

   task automatic measure_ref(input int p, output int cyc, output int hi, output int hp);
      logic pv;
      int r = 0;
      cyc = 0; hi = 0; hp = 0;
      do begin
         pv = ref_o;
         @(negedge ref_clk);
      end while (!(ref_o && !pv));
      while (r < p) begin
         cyc++;
         if (ref_o) hi++;
         if (ref_p) hp++;
         pv = ref_o;
         @(negedge ref_clk);
         if (ref_o && !pv) r++;
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual %0d expected %0d", 0, 1);
         finish_run();
      end
   end

   initial begin
      longint cyc;
      int hi, hp, badl, rc, rh, rp, len;
      logic pv;
      logic [7:0]  mv;
      logic [31:0] kv;
      void'($urandom(32'd4711));

      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 fb low", fb_o, 0);
      chk("R1 ref low", ref_o, 0);
      chk("R1 err clear", err, 0);
      chk("R1 lock_ok high", lock_ok, 1);
      rst_n = 1'b1;

      // R3 integer mode, minimum modulus
      restart(1'b0, 8'd8, '0, 2'd0);
      measure_fb(64, 8, cyc, hi, hp, badl);
      chk("R3 int M=8 total", cyc, 2 * 8 * 64);
      chk("R3 int M=8 high cycles", hi, 8 * 64);
      chk("R10 pulse fb highs", hp, 64);
      restart(1'b0, 8'd127, '0, 2'd0);
      measure_fb(8, 127, cyc, hi, hp, badl);
      chk("R3 int M=127 total", cyc, 2 * 127 * 8);
      chk("R3 int M=127 high cycles", hi, 127 * 8);
      for (int i = 0; i < 3; i++) begin
         mv = 8'(8 + ($urandom % 120));
         restart(1'b0, mv, $urandom, 2'd0);
         measure_fb(16, mv, cyc, hi, hp, badl);
         chk("R3 int random total", cyc, 2 * longint'(mv) * 16);
         chk("R3 int random duty", hi, mv * 16);
      end
      chk("R6 no error for legal settings", err, 0);

      // R4/R5 fractional mode
      for (int i = 0; i < 3; i++) begin
         mv = 8'(11 + ($urandom % 10));
         kv = $urandom;
         if (kv == 0) kv = 32'd7;
         restart(1'b1, mv, kv, 2'd0);
         measure_fb(512, mv, cyc, hi, hp, badl);
         chk("R4 frac random total", cyc, frac_total(mv, kv, 512));
         chk("R5 frac period lengths", badl, 0);
         chk("R10 pulse fb highs frac", hp, 512);
      end
      restart(1'b1, 8'd11, 32'd1, 2'd0);
      measure_fb(512, 11, cyc, hi, hp, badl);
      chk("R4 frac K=1 total", cyc, frac_total(11, 32'd1, 512));
      restart(1'b1, 8'd11, 32'h8000_0000, 2'd0);
      measure_fb(256, 11, cyc, hi, hp, badl);
      chk("R4 frac K=half total", cyc, frac_total(11, 32'h8000_0000, 256));
      chk("R5 frac K=half lengths", badl, 0);
      restart(1'b1, 8'd123, 32'hFFFF_FFFF, 2'd0);
      measure_fb(128, 123, cyc, hi, hp, badl);
      chk("R4 frac K=max total", cyc, frac_total(123, 32'hFFFF_FFFF, 128));
      chk("R5 frac K=max lengths", badl, 0);

      // R7 change mid-period
      restart(1'b0, 8'd10, '0, 2'd0);
      @(negedge clk);
      len = 0;
      forever begin
         len++;
         if (len == 5) m = 8'd30;
         pv = fb_o;
         @(negedge clk);
         if (fb_o && !pv) break;
      end
      chk("R7 current period keeps old M", len, 20);
      measure_fb(1, 30, cyc, hi, hp, badl);
      chk("R7 next period uses new M", cyc, 60);

      // R8 lock-valid thresholds
      restart(1'b1, 8'd20, 32'd429496729, 2'd0);
      en = 1'b0; repeat (3) @(negedge clk);
      chk("R8 K at low bound", lock_ok, 0);
      k = 32'd429496730; repeat (3) @(negedge clk);
      chk("R8 K above low bound", lock_ok, 1);
      k = 32'd3865470566; repeat (3) @(negedge clk);
      chk("R8 K below high bound", lock_ok, 1);
      k = 32'd3865470567; repeat (3) @(negedge clk);
      chk("R8 K at high bound", lock_ok, 0);
      frac = 1'b0; repeat (3) @(negedge clk);
      chk("R8 integer mode lock ok", lock_ok, 1);

      // R2 reference divider
      for (int c = 1; c < 4; c++) begin
         restart(1'b0, 8'd20, '0, 2'(c));
         measure_ref(8, rc, rh, rp);
         chk("R2 ref period", rc, 8 * (1 << c));
         chk("R2 ref half duty", rh, 8 * (1 << (c - 1)));
         chk("R10 ref pulse highs", rp, 8);
      end
      restart(1'b0, 8'd20, '0, 2'd0);
      repeat (3) @(posedge ref_clk);
      #2;
      chk("R2 code 0 follows clock high", ref_o, 1);
      chk("R10 code 0 pulse held high", ref_p, 1);
      @(negedge ref_clk);
      #2;
      chk("R2 code 0 follows clock low", ref_o, 0);

      // R9 disable
      @(negedge clk);
      en = 1'b0;
      repeat (2) @(negedge clk);
      chk("R9 fb low when disabled", fb_o, 0);
      chk("R9 pulse fb low when disabled", fb_p, 0);
      repeat (2) @(negedge ref_clk);
      chk("R9 ref low when disabled", ref_o, 0);
      chk("R9 pulse ref low when disabled", ref_p, 0);

      // R6 clamping and sticky error
      restart(1'b1, 8'd200, '0, 2'd0);
      measure_fb(16, 123, cyc, hi, hp, badl);
      chk("R6 frac M high clamp, K=0 as 1", cyc, frac_total(123, 32'd1, 16));
      chk("R6 error set", err, 1);
      chk("R8 K substituted 1 lock off", lock_ok, 0);
      pulse_reset();
      chk("R1 reset clears error", err, 0);
      restart(1'b1, 8'd5, 32'h8000_0000, 2'd0);
      measure_fb(16, 11, cyc, hi, hp, badl);
      chk("R6 frac M low clamp", cyc, frac_total(11, 32'h8000_0000, 16));
      chk("R6 error set low clamp", err, 1);
      pulse_reset();
      restart(1'b0, 8'd3, '0, 2'd0);
      measure_fb(4, 8, cyc, hi, hp, badl);
      chk("R6 int M low clamp", cyc, 2 * 8 * 4);
      restart(1'b0, 8'd20, '0, 2'd0);
      repeat (4) @(negedge clk);
      chk("R6 error sticky after legal", err, 1);
      pulse_reset();
      restart(1'b0, 8'd250, '0, 2'd0);
      measure_fb(2, 127, cyc, hi, hp, badl);
      chk("R6 int M high clamp", cyc, 2 * 127 * 2);
      chk("R6 error set high clamp", err, 1);

      done = 1'b1;
      finish_run();
   end

endmodule